// File: doc/BRIEF.md
# Serial Transmit Queue with Buffer and FIFO

This block is the outgoing half of a synchronous serial port. The CPU writes bytes into it and the block shifts them onto a serial data line with a companion serial clock. Three paths are available. In the single path a write goes straight into the shift register. The double path adds a one-byte holding buffer in front of the shifter. The queued path adds a four-entry FIFO in front of that buffer, so up to five bytes can wait while transmission is off. The block reports whether the holding buffer is free. It pulses a per-byte transmit interrupt and a FIFO level interrupt. It can also drop its own transmit enable once everything queued has left the line.

The serial engine is a four-state machine. SH_IDLE means the shift register is empty. SH_HOLD means it holds a byte but the enable is off. SH_LOW is the half-bit with the serial clock low, and SH_HIGH is the half-bit with the clock high. These are the transitions:

- load: SH_IDLE to SH_HOLD.
- go: SH_HOLD to SH_LOW, taken while transmit enable is set.
- rise: SH_LOW to SH_HIGH, on a bit tick.
- next bit: SH_HIGH to SH_LOW, on a tick while bits remain.
- finish: SH_HIGH to SH_IDLE, on the tick of the last bit.

Each bit occupies one low phase and one high phase, and each phase lasts one `bit_tick` pulse. The receiver samples on the rising clock edge.

The path is picked by `cfg_dbuf` and `cfg_fifo_en`. When `cfg_dbuf` is 0 the single path is used. When `cfg_dbuf` is 1 and `cfg_fifo_en` is 0 the double path is used. When both are 1 the queued path is used. Software clears the FIFO with `fifo_clr` after choosing the path.

Top module: `sertx_path`

## Requirements
- R1: After reset, `sclk` and `sdo` are 1, `buf_empty` is 1, and `txe` is 0. `fifo_count`, `overrun`, `irq_tx` and `irq_fifo` are all 0.
- R2: In the single path (`cfg_dbuf`=0), a write to an idle shifter loads it directly. `irq_tx` pulses for one cycle only after the last bit has shifted out. `cfg_fifo_en` has no effect in this path.
- R3: In the double path, a write into a free buffer drives `buf_empty` to 0 on the next cycle. When the byte moves into the shifter, `buf_empty` returns to 1 and `irq_tx` pulses in that same cycle, before any bit is shifted.
- R4: Each byte is sent as 8 bits. During a bit, `sclk` is low for one tick phase and then high for one tick phase, and `sdo` is valid throughout. The byte is sent MSB first when `cfg_lsb_first`=0 and LSB first when it is 1. While no bit is shifting, `sclk` and `sdo` stay at 1.
- R5: While `txe` is 0, queued data is not shifted and `tx_busy` stays 0. A `txe_set` pulse starts the transfer.
- R6: In the queued path, five bytes can be held with transmission off: one in the buffer and four in the FIFO. `fifo_count` reports the FIFO occupancy.
- R7: Bytes leave the line in the order they were written, across FIFO, buffer and shifter.
- R8: `irq_fifo` pulses when a move from the FIFO into the buffer leaves the FIFO holding exactly `cfg_level` bytes. With a level of 0, this is the move of the last FIFO byte.
- R9: A write that cannot be accepted is dropped and sets `overrun`. This happens when the shifter is busy in the single path, when the buffer is full in the double path, and when the FIFO is full in the queued path. `overrun` stays set until an `ovr_clr` pulse clears it.
- R10: A `fifo_clr` pulse empties the FIFO on the next cycle without touching the buffer. Discarded bytes raise no `irq_fifo`.
- R11: With `cfg_auto_off`=1, `txe` drops when a byte finishes and nothing is left in the buffer or FIFO, and `sclk` then stays high. With `cfg_auto_off`=0, `txe` stays set. Outside `txe_clr`, `txe` never falls unless auto-off is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | W | CPU write byte |
| cfg_dbuf | input | 1 | Selects the holding buffer |
| cfg_fifo_en | input | 1 | Selects the FIFO; only takes effect with `cfg_dbuf` |
| cfg_lsb_first | input | 1 | 1 sends the LSB first |
| cfg_auto_off | input | 1 | Drop `txe` when the queue drains |
| cfg_level | input | CW | FIFO level that raises `irq_fifo` |
| fifo_clr | input | 1 | Empties the FIFO |
| txe_set | input | 1 | Sets transmit enable |
| txe_clr | input | 1 | Clears transmit enable |
| ovr_clr | input | 1 | Clears `overrun` |
| bit_tick | input | 1 | Half-bit timing strobe |
| sclk | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data |
| tx_busy | output | 1 | A bit is being shifted |
| txe | output | 1 | Transmit enable state |
| buf_empty | output | 1 | Holding buffer is free |
| fifo_count | output | CW | FIFO occupancy |
| overrun | output | 1 | Sticky flag for a dropped write |
| irq_tx | output | 1 | One-cycle transmit interrupt |
| irq_fifo | output | 1 | One-cycle FIFO level interrupt |

## Verification
Suppose the buffer-full state, the FIFO pointers or the shifter's bit counter goes wrong. The bench would then see a lost, repeated or reordered byte, or a byte of the wrong length, on the serial line. That shows up at most about 17 ticks later, once the affected byte has been captured. An interrupt raised in the wrong place shows as a count that differs for a single byte. A `buf_empty` or `fifo_count` that updates in the wrong cycle is caught within one clock, because those outputs are sampled in the cycle right after the write or the enable. A fault in auto-off shows at once as `txe` still set, or cleared too early, when a transfer ends.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_HOLD,
        SH_LOW,
        SH_HIGH
    } sh_state_t;

    typedef enum logic [1:0] {
        PATH_SINGLE,
        PATH_DOUBLE,
        PATH_QUEUED
    } path_mode_t;

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= advance(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= advance(rd_ptr);
            end
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_comb begin
        head  = mem[rd_ptr];
        count = cnt;
        full  = (cnt == CW'(DEPTH));
        empty = (cnt == '0);
    end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] ldata,
    input  logic         go,
    input  logic         lsb_first,
    output logic         sclk,
    output logic         sdo,
    output logic         idle,
    output logic         busy,
    output logic         done
);
    localparam int BW = $clog2(W);

    sh_state_t     state;
    sh_state_t     state_nx;
    logic [W-1:0]  sh;
    logic [BW-1:0] bcnt;
    logic          last_bit;

    assign last_bit = (bcnt == BW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE: if (load) state_nx = SH_HOLD;
            SH_HOLD: if (go)   state_nx = SH_LOW;
            SH_LOW:  if (tick) state_nx = SH_HIGH;
            SH_HIGH: if (tick) state_nx = last_bit ? SH_IDLE : SH_LOW;
            default: state_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            bcnt <= '0;
        end else if (state == SH_IDLE && load) begin
            sh   <= ldata;
            bcnt <= '0;
        end else if (state == SH_HIGH && tick) begin
            sh   <= lsb_first ? (sh >> 1) : (sh << 1);
            bcnt <= bcnt + 1'b1;
        end
    end

    always_comb begin
        busy = (state == SH_LOW) || (state == SH_HIGH);
        idle = (state == SH_IDLE);
        sclk = (state != SH_LOW);
        sdo  = busy ? (lsb_first ? sh[0] : sh[W-1]) : 1'b1;
        done = (state == SH_HIGH) && tick && last_bit;
    end

endmodule

// File: rtl/sertx_path.sv
module sertx_path
    import sertx_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          cfg_dbuf,
    input  logic          cfg_fifo_en,
    input  logic          cfg_lsb_first,
    input  logic          cfg_auto_off,
    input  logic [CW-1:0] cfg_level,
    input  logic          fifo_clr,
    input  logic          txe_set,
    input  logic          txe_clr,
    input  logic          ovr_clr,
    input  logic          bit_tick,
    output logic          sclk,
    output logic          sdo,
    output logic          tx_busy,
    output logic          txe,
    output logic          buf_empty,
    output logic [CW-1:0] fifo_count,
    output logic          overrun,
    output logic          irq_tx,
    output logic          irq_fifo
);
    path_mode_t    mode;
    logic [W-1:0]  buf_q;
    logic          buf_full;
    logic          txe_q;
    logic          ovr_q;
    logic          irq_tx_q;
    logic          irq_fifo_q;

    logic          sh_idle;
    logic          sh_busy;
    logic          sh_done;
    logic          sh_load;
    logic [W-1:0]  sh_data;

    logic [W-1:0]  f_head;
    logic [CW-1:0] f_cnt;
    logic [CW-1:0] f_cnt_nx;
    logic          f_full;
    logic          f_empty;
    logic          f_push;
    logic          f_pop;

    logic          buf_load;
    logic          dbl_wr;
    logic          sgl_wr;
    logic          rejected;
    logic          queue_dry;

    always_comb begin
        if (!cfg_dbuf) begin
            mode = PATH_SINGLE;
        end else if (cfg_fifo_en) begin
            mode = PATH_QUEUED;
        end else begin
            mode = PATH_DOUBLE;
        end
    end

    always_comb begin
        buf_load  = (mode != PATH_SINGLE) && buf_full && sh_idle && txe_q;
        f_pop     = (mode == PATH_QUEUED) && !f_empty && !fifo_clr
                    && (!buf_full || buf_load);
        f_push    = (mode == PATH_QUEUED) && wr_en && !f_full && !fifo_clr;
        dbl_wr    = (mode == PATH_DOUBLE) && wr_en && !buf_full;
        sgl_wr    = (mode == PATH_SINGLE) && wr_en && sh_idle;
        rejected  = wr_en && !(f_push || dbl_wr || sgl_wr)
                    && !((mode == PATH_QUEUED) && fifo_clr);
        sh_load   = sgl_wr || buf_load;
        sh_data   = sgl_wr ? wr_data : buf_q;
        f_cnt_nx  = f_cnt + CW'(f_push) - CW'(f_pop);
        queue_dry = !buf_full && ((mode != PATH_QUEUED) || f_empty);
    end

    sertx_fifo #(
        .W    (W),
        .DEPTH(DEPTH),
        .CW   (CW)
    ) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (fifo_clr),
        .push (f_push),
        .din  (wr_data),
        .pop  (f_pop),
        .head (f_head),
        .count(f_cnt),
        .full (f_full),
        .empty(f_empty)
    );

    sertx_shift #(
        .W(W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .load     (sh_load),
        .ldata    (sh_data),
        .go       (txe_q),
        .lsb_first(cfg_lsb_first),
        .sclk     (sclk),
        .sdo      (sdo),
        .idle     (sh_idle),
        .busy     (sh_busy),
        .done     (sh_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
        end else if (f_pop) begin
            buf_q    <= f_head;
            buf_full <= 1'b1;
        end else if (dbl_wr) begin
            buf_q    <= wr_data;
            buf_full <= 1'b1;
        end else if (buf_load) begin
            buf_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txe_q      <= 1'b0;
            ovr_q      <= 1'b0;
            irq_tx_q   <= 1'b0;
            irq_fifo_q <= 1'b0;
        end else begin
            if (txe_clr) begin
                txe_q <= 1'b0;
            end else if (txe_set) begin
                txe_q <= 1'b1;
            end else if (cfg_auto_off && sh_done && queue_dry) begin
                txe_q <= 1'b0;
            end
            if (ovr_clr) begin
                ovr_q <= 1'b0;
            end else if (rejected) begin
                ovr_q <= 1'b1;
            end
            irq_tx_q   <= (mode == PATH_SINGLE) ? sh_done : buf_load;
            irq_fifo_q <= f_pop && (f_cnt_nx == cfg_level);
        end
    end

    always_comb begin
        tx_busy    = sh_busy;
        txe        = txe_q;
        buf_empty  = !buf_full;
        fifo_count = f_cnt;
        overrun    = ovr_q;
        irq_tx     = irq_tx_q;
        irq_fifo   = irq_fifo_q;
    end

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          cfg_dbuf,
    input logic          cfg_fifo_en,
    input logic          cfg_auto_off,
    input logic          fifo_clr,
    input logic          txe_clr,
    input logic          ovr_clr,
    input logic          sclk,
    input logic          tx_busy,
    input logic          txe,
    input logic          buf_empty,
    input logic [CW-1:0] fifo_count,
    input logic          overrun,
    input logic          irq_tx
);
    AST_IRQ_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq_tx |=> !irq_tx); // R2
    AST_WRITE_FILLS_BUF: assert property (@(posedge clk) disable iff (!rst_n) (cfg_dbuf && !cfg_fifo_en && wr_en && buf_empty) |=> !buf_empty); // R3
    AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !tx_busy |-> sclk); // R4
    AST_SHIFT_NEEDS_TXE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> $past(txe)); // R5
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fifo_count <= CW'(DEPTH)); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (overrun && !ovr_clr) |=> overrun); // R9
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) fifo_clr |=> (fifo_count == '0)); // R10
    AST_TXE_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(txe) |-> ($past(txe_clr) || $past(cfg_auto_off))); // R11
endmodule

bind sertx_path sertx_chk #(
    .DEPTH(DEPTH),
    .CW   (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .cfg_dbuf    (cfg_dbuf),
    .cfg_fifo_en (cfg_fifo_en),
    .cfg_auto_off(cfg_auto_off),
    .fifo_clr    (fifo_clr),
    .txe_clr     (txe_clr),
    .ovr_clr     (ovr_clr),
    .sclk        (sclk),
    .tx_busy     (tx_busy),
    .txe         (txe),
    .buf_empty   (buf_empty),
    .fifo_count  (fifo_count),
    .overrun     (overrun),
    .irq_tx      (irq_tx)
);

// File: tb/sim_sertx_path.sv
module sim_sertx_path;

    localparam int W     = 8;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic         dbuf;
        logic         fifo;
        logic         lsb;
        logic [W-1:0] din;
        logic [W-1:0] expv;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1'b0, 1'b0, 1'b0, 8'hC3, 8'hC3},
        '{1'b0, 1'b0, 1'b1, 8'h01, 8'h80},
        '{1'b0, 1'b1, 1'b0, 8'h81, 8'h81},
        '{1'b1, 1'b0, 1'b0, 8'h5A, 8'h5A},
        '{1'b1, 1'b0, 1'b1, 8'hF0, 8'h0F},
        '{1'b1, 1'b1, 1'b0, 8'h3C, 8'h3C},
        '{1'b1, 1'b1, 1'b1, 8'h12, 8'h48}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          cfg_dbuf = 1'b0;
    logic          cfg_fifo_en = 1'b0;
    logic          cfg_lsb_first = 1'b0;
    logic          cfg_auto_off = 1'b0;
    logic [CW-1:0] cfg_level = '0;
    logic          fifo_clr = 1'b0;
    logic          txe_set = 1'b0;
    logic          txe_clr = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          bit_tick = 1'b1;
    logic          sclk;
    logic          sdo;
    logic          tx_busy;
    logic          txe;
    logic          buf_empty;
    logic [CW-1:0] fifo_count;
    logic          overrun;
    logic          irq_tx;
    logic          irq_fifo;

    int n_chk = 0;
    int n_err = 0;

    logic [W-1:0] caps [64];
    int           cap_n = 0;
    int           cap_bits = 0;
    logic [W-1:0] cap_sh = '0;
    logic         prev_sclk = 1'b1;
    int           n_itx = 0;
    int           n_ifi = 0;

    always #5 clk = ~clk;

    sertx_path #(.W(W), .DEPTH(DEPTH), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_dbuf(cfg_dbuf), .cfg_fifo_en(cfg_fifo_en),
        .cfg_lsb_first(cfg_lsb_first), .cfg_auto_off(cfg_auto_off),
        .cfg_level(cfg_level), .fifo_clr(fifo_clr), .txe_set(txe_set),
        .txe_clr(txe_clr), .ovr_clr(ovr_clr), .bit_tick(bit_tick),
        .sclk(sclk), .sdo(sdo), .tx_busy(tx_busy), .txe(txe),
        .buf_empty(buf_empty), .fifo_count(fifo_count), .overrun(overrun),
        .irq_tx(irq_tx), .irq_fifo(irq_fifo)
    );

    // serial capture: a bit is taken whenever sclk is seen falling
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_sclk && !sclk) begin
                cap_sh = {cap_sh[W-2:0], sdo};
                cap_bits++;
                if (cap_bits == W) begin
                    if (cap_n < 64) caps[cap_n] = cap_sh;
                    cap_n++;
                    cap_bits = 0;
                end
            end
            prev_sclk = sclk;
            if (irq_tx) n_itx++;
            if (irq_fifo) n_ifi++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [W-1:0] d);
        wr_data = d;
        wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_txe_set();
        txe_set = 1'b1;
        cyc(1);
        txe_set = 1'b0;
    endtask

    task automatic pulse_txe_clr();
        txe_clr = 1'b1;
        cyc(1);
        txe_clr = 1'b0;
    endtask

    task automatic pulse_fifo_clr();
        fifo_clr = 1'b1;
        cyc(1);
        fifo_clr = 1'b0;
    endtask

    task automatic pulse_ovr_clr();
        ovr_clr = 1'b1;
        cyc(1);
        ovr_clr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int base;
        int it0;
        int if0;
        cyc(3);
        // R1 reset state
        chk("R1 sclk", sclk, 1);
        chk("R1 sdo", sdo, 1);
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 txe", txe, 0);
        chk("R1 fifo_count", fifo_count, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 irqs", {irq_tx, irq_fifo}, 0);
        rst_n = 1'b1;
        cyc(2);

        // table walk: one byte per row, all paths and bit orders (R2 R3 R4 R11)
        for (int i = 0; i < 7; i++) begin
            cfg_dbuf = VEC[i].dbuf;
            cfg_fifo_en = VEC[i].fifo;
            cfg_lsb_first = VEC[i].lsb;
            cfg_auto_off = 1'b1;
            if (VEC[i].dbuf && VEC[i].fifo) pulse_fifo_clr();
            base = cap_n;
            it0 = n_itx;
            write(VEC[i].din);
            cyc(3);
            pulse_txe_set();
            cyc(40);
            chk("R4 serial byte", caps[base], VEC[i].expv);
            chk("R7 byte count", cap_n - base, 1);
            chk("R2 R3 irq_tx count", n_itx - it0, 1);
            chk("R11 auto off", txe, 0);
            chk("R4 idle line", {sclk, sdo}, 2'b11);
        end

        // R2 single path: interrupt only after the last bit
        cfg_dbuf = 1'b0; cfg_fifo_en = 1'b0; cfg_lsb_first = 1'b0; cfg_auto_off = 1'b1;
        it0 = n_itx;
        write(8'hA7);
        pulse_txe_set();
        cyc(8);
        chk("R2 no irq mid byte", n_itx - it0, 0);
        chk("R2 busy mid byte", tx_busy, 1);
        cyc(20);
        chk("R2 irq after byte", n_itx - it0, 1);

        // R3 R5 double path timing
        cfg_dbuf = 1'b1; cfg_auto_off = 1'b0;
        it0 = n_itx;
        write(8'h96);
        chk("R3 buf_empty cleared", buf_empty, 0);
        cyc(3);
        chk("R5 held without txe", tx_busy, 0);
        chk("R5 buffer kept", buf_empty, 0);
        pulse_txe_set();
        cyc(1);
        chk("R3 buf_empty set on move", buf_empty, 1);
        chk("R3 irq on move", irq_tx, 1);
        chk("R3 no bit yet", tx_busy, 0);
        cyc(30);
        chk("R11 txe kept", txe, 1);
        pulse_txe_clr();

        // R9 overrun in double path
        base = cap_n;
        write(8'h11);
        write(8'h22);
        chk("R9 overrun set", overrun, 1);
        cyc(3);
        chk("R9 overrun sticky", overrun, 1);
        pulse_ovr_clr();
        chk("R9 overrun cleared", overrun, 0);
        pulse_txe_set();
        cyc(30);
        chk("R9 dropped byte", cap_n - base, 1);
        chk("R9 kept byte", caps[base], 8'h11);
        pulse_txe_clr();

        // R6 R7 R8 R11 queued path, five bytes
        cfg_fifo_en = 1'b1; cfg_auto_off = 1'b1; cfg_level = '0;
        pulse_fifo_clr();
        base = cap_n;
        if0 = n_ifi;
        write(8'h11); write(8'h22); write(8'h33); write(8'h44); write(8'h55);
        cyc(2);
        chk("R6 fifo full count", fifo_count, 4);
        chk("R6 buffer holds", buf_empty, 0);
        write(8'h66);
        chk("R9 fifo overrun", overrun, 1);
        chk("R9 count unchanged", fifo_count, 4);
        pulse_ovr_clr();
        pulse_txe_set();
        cyc(120);
        chk("R7 five bytes", cap_n - base, 5);
        for (int k = 0; k < 5; k++) begin
            chk("R7 order", caps[base + k], 32'h11 * (k + 1));
        end
        chk("R8 level 0 irq", n_ifi - if0, 1);
        chk("R11 queue drained off", txe, 0);
        chk("R11 clock parked", sclk, 1);

        // R8 level 2
        pulse_fifo_clr();
        write(8'hA1); write(8'hA2); write(8'hA3); write(8'hA4);
        cyc(2);
        chk("R6 three queued", fifo_count, 3);
        cfg_level = CW'(2);
        if0 = n_ifi;
        pulse_txe_set();
        cyc(90);
        chk("R8 level 2 irq", n_ifi - if0, 1);
        cfg_level = '0;

        // R10 fifo clear keeps buffer
        base = cap_n;
        write(8'hB1); write(8'hB2); write(8'hB3);
        cyc(2);
        if0 = n_ifi;
        pulse_fifo_clr();
        chk("R10 fifo emptied", fifo_count, 0);
        chk("R10 buffer kept", buf_empty, 0);
        pulse_txe_set();
        cyc(30);
        chk("R10 one byte out", cap_n - base, 1);
        chk("R10 byte value", caps[base], 8'hB1);
        chk("R10 no fifo irq", n_ifi - if0, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule